// File: doc/BRIEF.md
# Camera Sensor Register Initialisation Sequencer

This block brings an image sensor out of power-up by loading its control registers over a shared byte-level I2C master. After reset it counts a fixed power-up settling time on the system clock. It then reads a register table one entry at a time. For each entry it issues three commands to the master and waits for the master's completion pulse after each one. When the last entry has been written, it raises a configuration-complete flag. Pixel capture and display logic use this flag as their enable.

The master interface has a one-cycle request strobe, a 4-bit one-hot command word and a data byte. The master answers each request with a done pulse. Only one request is ever outstanding. The settling time, the number of table entries and the sensor bus address are parameters, so a small configuration can be exercised quickly. The table content is a computed placeholder.

Top module: `cam_cfg_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mst_req` and `cfg_ready` are both 0.
- R2: The first request strobe appears in exactly the cycle `SETTLE_CYCLES + 1` clock edges after reset is released. No request appears earlier.
- R3: The command bits are one-hot, with bit 0 = start, bit 1 = write, bit 2 = read and bit 3 = stop. Each entry is sent as three requests in order:
  - `4'b0011` carrying `SENSOR_ADDR`
  - `4'b0010` carrying the entry's sub-address
  - `4'b1010` carrying the entry's data byte
- R4: Entries are sent in ascending index k = 0 .. `REG_COUNT`-1. Entry k has sub-address (3k+1) mod 256 and data ((7k) mod 256) XOR 8'hA5.
- R5: Each request strobe lasts one cycle. The next request is raised in the cycle right after the one in which `mst_done` is sampled high, and never before that.
- R6: A `mst_done` pulse that arrives while no request is outstanding has no effect. This covers pulses during the settling wait and pulses after completion.
- R7: Exactly 3 × `REG_COUNT` requests are issued after a reset, and none follow.
- R8: `cfg_ready` is 0 up to the last done pulse. It is 1 in the cycle after that pulse and stays 1 until the next reset.
- R9: A reset during the sequence restarts the full settling wait and the table walk from entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req | output | 1 | One-cycle request strobe to the I2C master |
| mst_cmd | output | 4 | One-hot command: bit0 start, bit1 write, bit2 read, bit3 stop |
| mst_byte | output | 8 | Byte carried with the command |
| mst_done | input | 1 | Completion pulse from the I2C master |
| cfg_ready | output | 1 | Sticky configuration-complete flag |

## Verification
A wrong settling count shows up as the first strobe landing off cycle `SETTLE_CYCLES + 1`. This is visible the moment the first request appears. A wrong phase or index counter shows up on the very next request, as a command word or byte that differs from the arithmetic expected for that position. A walk that skips or repeats entries changes the request total and moves the rise of the ready flag. A leaked done pulse, during the wait or after completion, shows as an extra or early strobe within a cycle of the pulse.

// File: rtl/cam_cfg_seq_pkg.sv
// Package: shared command encodings and sequencer states.
// Assumes the master decodes the command word as one-hot bits.
package cam_cfg_seq_pkg;
    localparam logic [3:0] CMD_START = 4'b0001;
    localparam logic [3:0] CMD_WRITE = 4'b0010;
    localparam logic [3:0] CMD_READ  = 4'b0100;
    localparam logic [3:0] CMD_STOP  = 4'b1000;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FIN    = 2'd3
    } seq_state_t;

    // Phase inside one register write
    typedef enum logic [1:0] {
        PH_DEV  = 2'd0,
        PH_SUB  = 2'd1,
        PH_DATA = 2'd2
    } seq_phase_t;
endpackage

// File: rtl/cfg_settle_timer.sv
// Power-up settling timer.
// Counts SETTLE_CYCLES clock edges after reset is released, then holds
// `expired` high until the next reset. Assumes SETTLE_CYCLES >= 1.
module cfg_settle_timer #(
    parameter int SETTLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count edges until the settling window has elapsed, then freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(SETTLE_CYCLES - 1))
                expired <= 1'b1;
        end
    end

    // R2
    expire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> cnt == CW'(SETTLE_CYCLES));

    // R2
    expire_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
endmodule

// File: rtl/cfg_reg_table.sv
// Register table for the sensor.
// Maps an entry index to a {sub-address, data} pair. The content is a
// computed placeholder. Assumes the index is below REG_COUNT.
module cfg_reg_table #(
    parameter int REG_COUNT = 252,
    parameter int IW        = $clog2(REG_COUNT)
) (
    input  logic [IW-1:0] idx,
    output logic [7:0]    sub_addr,
    output logic [7:0]    wr_data
);
    logic [15:0] k;

    // Compute the placeholder pair for the selected entry
    always_comb begin
        k        = 16'(idx);
        sub_addr = 8'(k * 16'd3 + 16'd1);
        wr_data  = 8'(k * 16'd7) ^ 8'hA5;
    end
endmodule

// File: rtl/cfg_walk_fsm.sv
// Table-walk control.
// Once the timer expires, it issues three master commands per table entry
// and waits for the done pulse after each one. After the last entry it
// parks in a final state that drives the ready flag.
// Assumes the master raises done only after it has seen a request.
module cfg_walk_fsm
    import cam_cfg_seq_pkg::*;
#(
    parameter int         REG_COUNT   = 252,
    parameter int         IW          = $clog2(REG_COUNT),
    parameter logic [7:0] SENSOR_ADDR = 8'h78
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          timer_expired,
    input  logic          mst_done,
    input  logic [7:0]    ent_sub,
    input  logic [7:0]    ent_data,
    output logic [IW-1:0] ent_idx,
    output logic          mst_req,
    output logic [3:0]    mst_cmd,
    output logic [7:0]    mst_byte,
    output logic          cfg_ready
);
    seq_state_t state;
    seq_phase_t phase;
    logic       last_ent;

    assign last_ent = (ent_idx == IW'(REG_COUNT - 1));

    // Sequencing: settle -> (issue -> wait) x 3 x REG_COUNT -> final
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SETTLE;
            phase   <= PH_DEV;
            ent_idx <= '0;
        end else begin
            case (state)
                ST_SETTLE: if (timer_expired) state <= ST_ISSUE;
                ST_ISSUE:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (mst_done) begin
                        if (phase != PH_DATA) begin
                            phase <= seq_phase_t'(phase + 2'd1);
                            state <= ST_ISSUE;
                        end else if (last_ent) begin
                            state <= ST_FIN;
                        end else begin
                            phase   <= PH_DEV;
                            ent_idx <= ent_idx + 1'b1;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_FIN;
            endcase
        end
    end

    // Command word and byte for the current phase
    always_comb begin
        case (phase)
            PH_DEV:  begin mst_cmd = CMD_START | CMD_WRITE; mst_byte = SENSOR_ADDR; end
            PH_SUB:  begin mst_cmd = CMD_WRITE;             mst_byte = ent_sub;     end
            default: begin mst_cmd = CMD_WRITE | CMD_STOP;  mst_byte = ent_data;    end
        endcase
    end

    assign mst_req   = (state == ST_ISSUE);
    assign cfg_ready = (state == ST_FIN);

    // Tracks whether a request is waiting for its done pulse (checking only)
    logic pending;
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (mst_req)  pending <= 1'b1;
        else if (mst_done) pending <= 1'b0;
    end

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |=> !mst_req);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |-> !pending);

    // R2
    req_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |-> timer_expired);

    // R3
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |-> (mst_cmd == 4'b0011 || mst_cmd == 4'b0010 || mst_cmd == 4'b1010));

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready);

    // R7
    quiet_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> !mst_req);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_idx <= IW'(REG_COUNT - 1));
endmodule

// File: rtl/cam_cfg_seq.sv
// Top of the sensor register initialisation sequencer.
// Joins the settling timer, the register table and the walk control.
// Assumes a synchronous active-low reset and a master that gives one
// done pulse per request.
module cam_cfg_seq #(
    parameter int         SETTLE_CYCLES = 1_000_000,
    parameter int         REG_COUNT     = 252,
    parameter logic [7:0] SENSOR_ADDR   = 8'h78
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       mst_req,
    output logic [3:0] mst_cmd,
    output logic [7:0] mst_byte,
    input  logic       mst_done,
    output logic       cfg_ready
);
    localparam int IW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic          expired;
    logic [IW-1:0] ent_idx;
    logic [7:0]    ent_sub;
    logic [7:0]    ent_data;

    cfg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (expired)
    );

    cfg_reg_table #(.REG_COUNT(REG_COUNT), .IW(IW)) u_table (
        .idx      (ent_idx),
        .sub_addr (ent_sub),
        .wr_data  (ent_data)
    );

    cfg_walk_fsm #(.REG_COUNT(REG_COUNT), .IW(IW), .SENSOR_ADDR(SENSOR_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .timer_expired (expired),
        .mst_done      (mst_done),
        .ent_sub       (ent_sub),
        .ent_data      (ent_data),
        .ent_idx       (ent_idx),
        .mst_req       (mst_req),
        .mst_cmd       (mst_cmd),
        .mst_byte      (mst_byte),
        .cfg_ready     (cfg_ready)
    );
endmodule

// File: tb/cam_cfg_seq_tb.sv
module cam_cfg_seq_tb;
    localparam int         D   = 40;
    localparam int         N   = 5;
    localparam logic [7:0] DEV = 8'h78;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_done = 1'b0;
    logic       mst_req;
    logic [3:0] mst_cmd;
    logic [7:0] mst_byte;
    logic       cfg_ready;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int n_req = 0;

    cam_cfg_seq #(.SETTLE_CYCLES(D), .REG_COUNT(N), .SENSOR_ADDR(DEV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_req   (mst_req),
        .mst_cmd   (mst_cmd),
        .mst_byte  (mst_byte),
        .mst_done  (mst_done),
        .cfg_ready (cfg_ready)
    );

    always #2 clk = ~clk;

    // Clock edges counted since reset was released
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Requests counted as seen away from the active edge
    always @(negedge clk) if (rst_n && mst_req) n_req <= n_req + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mst_req == 1'b0 && cfg_ready == 1'b0, "R1", {mst_req, cfg_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mst_req == 1'b0 && cfg_ready == 1'b0, "R1", {mst_req, cfg_ready}, 0);
    endtask

    // Answer ntx requests; the master latency varies with lb
    task automatic run_seq(input int ntx, input int lb);
        for (int t = 0; t < ntx; t++) begin
            int g = 0;
            int k = t / 3;
            int ph = t % 3;
            logic [3:0] ecmd;
            logic [7:0] eb;
            int lat;
            while (!mst_req && g < 2000) begin @(negedge clk); g++; end
            if (!mst_req) begin chk(1'b0, "R7", 0, 1); return; end
            if (t == 0) chk(cyc == D + 1, "R2", cyc, D + 1);
            ecmd = (ph == 0) ? 4'b0011 : (ph == 1) ? 4'b0010 : 4'b1010;
            eb   = (ph == 0) ? DEV : (ph == 1) ? 8'((3 * k + 1) % 256)
                                                : (8'((7 * k) % 256) ^ 8'hA5);
            chk(mst_cmd == ecmd, "R3", mst_cmd, ecmd);
            chk(mst_byte == eb, (ph == 0) ? "R3" : "R4", mst_byte, eb);
            lat = 1 + ((t + lb) % 3);
            @(negedge clk);
            chk(mst_req == 1'b0, "R5", mst_req, 0);
            repeat (lat - 1) @(negedge clk);
            if (t == 3 * N - 1) chk(cfg_ready == 1'b0, "R8", cfg_ready, 0);
            mst_done = 1'b1;
            @(negedge clk);
            mst_done = 1'b0;
            if (t == 3 * N - 1)    chk(cfg_ready == 1'b1, "R8", cfg_ready, 1);
            else if (t < ntx - 1)  chk(mst_req == 1'b1, "R5", mst_req, 1);
        end
    endtask

    initial begin
        int base;
        // Partial walk, then a reset part-way through (R9)
        do_reset();
        run_seq(7, 0);
        do_reset();
        chk(cfg_ready == 1'b0, "R9", cfg_ready, 0);
        // Stray done pulse during the settling wait (R6)
        repeat (5) @(negedge clk);
        mst_done = 1'b1;
        @(negedge clk);
        mst_done = 1'b0;
        base = n_req;
        run_seq(3 * N, 1);   // R9: restarts from entry 0 with full settle
        repeat (20) @(negedge clk);
        // Stray done pulse after completion (R6)
        mst_done = 1'b1;
        @(negedge clk);
        mst_done = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_req - base == 3 * N, "R7", n_req - base, 3 * N);
        chk(n_req - base == 3 * N, "R6", n_req - base, 3 * N);
        chk(cfg_ready == 1'b1, "R8", cfg_ready, 1);
        // Full walk again with another latency pattern
        do_reset();
        base = n_req;
        run_seq(3 * N, 2);
        repeat (10) @(negedge clk);
        chk(n_req - base == 3 * N, "R7", n_req - base, 3 * N);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule